// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked host and an external asynchronous static RAM that holds one data bit per word. Each access is one handshake. The host raises `req_valid` with an address, a write flag and, for writes, one data bit. The controller accepts the request on a clock edge where `req_ready` is high. It then plays out the pin sequence on the memory side and goes back to idle. A read returns its bit through a one-cycle `rd_valid` pulse carrying `rd_data`.

Every memory timing limit is a nanosecond parameter: the clock period, the minimum cycle time, the write-pulse width, the data setup and the access time. Each one becomes a whole number of clock cycles by rounding up. Writes are timed by the write-enable pulse. Write enable always rises at least one cycle before the select line, so the edge that ends the write is known. Between accesses the select line is held high, which lets the memory fall into standby.

The asynchronous reset `rst_n` is synchronised inside the block before it is used.

Top module: `sram_access_ctrl`

Derived counts, where ceil() rounds up:
- WR_CYC = max(ceil(T_PWE/CLK_NS), ceil(T_SD/CLK_NS))
- RD_CYC = ceil(T_AA/CLK_NS) + 1
- RC_CYC = ceil(T_RC/CLK_NS)

## Requirements
- R1: While `rst_n` is low, `mem_sel_n` and `mem_wr_n` are 1, `req_ready` is 0 and `rd_valid` is 0. After `rst_n` rises, `req_ready` stays 0 through the first two rising clock edges and becomes 1 after the third.
- R2: `mem_wr_n` is 0 only in cycles where `mem_sel_n` is also 0.
- R3: On an accepted write, `mem_sel_n` and `mem_wr_n` both fall on the next edge, together with the new `mem_addr` and `mem_wbit`. `mem_wr_n` stays 0 for exactly WR_CYC cycles. It rises while `mem_sel_n` is still 0, and `mem_sel_n` rises one cycle later, so the select window of a write is WR_CYC+1 cycles long.
- R4: `mem_addr` and `mem_wbit` do not change during any cycle in which `mem_sel_n` stays 0 from the cycle before.
- R5: On an accepted read, `mem_sel_n` is 0 with `mem_wr_n` at 1 for exactly RD_CYC cycles. On the edge that ends this window, `mem_rbit` is captured into `rd_data` and `rd_valid` is 1 for one cycle. There is exactly one such pulse per accepted read.
- R6: A request is taken only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the cycle after an acceptance and stays 0 until the access has finished.
- R7: Two acceptances are at least RC_CYC cycles apart. If `req_valid` is held high, the spacing after a write is exactly max(RC_CYC, WR_CYC+2) cycles and the spacing after a read is exactly max(RC_CYC, RD_CYC+1) cycles.
- R8: Whenever `req_ready` is 1, `mem_sel_n` and `mem_wr_n` are both 1, so the memory is deselected while idle.
- R9: Every read returns the bit most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 1 | Bit to write |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds the read result |
| rd_data | output | 1 | Last bit read from memory |
| mem_sel_n | output | 1 | Memory chip select, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_wbit | output | 1 | Memory write-data pin |
| mem_rbit | input | 1 | Memory read-data pin |

## Verification
If the phase counter is loaded with the wrong value, the select or write window has the wrong length. This shows at the pins within the access where it happens. If the capture comes one cycle early, the data is taken before the access time has elapsed. The bench's memory model returns the inverted bit during that period, so the very next `rd_valid` carries a wrong bit. A state machine stuck in a busy state holds `req_ready` low. The next request then times out, and a mistaken gap count shows up as a wrong start-to-start spacing on the following acceptance. The sweep writes and reads back every address of a 64-word configuration, with the data pattern and then its complement, in forward and reverse order and in interleaved write/read pairs.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_WREL  = 2'd2,
    ST_READ  = 2'd3
  } ctrl_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // The register is enabled only when it would actually change.
  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    if (load) begin
      cnt_d = load_val;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

  // R7: once expired, the timer stays expired until it is loaded again.
  p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_en,
  input  logic mem_rbit,
  output logic rd_valid,
  output logic rd_data
);

  logic data_q;
  logic valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 1'b0;
    end else if (capture_en) begin
      data_q <= mem_rbit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= capture_en;
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = data_q;

  // R5: the result strobe lasts a single cycle.
  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WR_CYC = 2,
  parameter int RD_CYC = 3,
  parameter int RC_CYC = 2,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              req_ready,
  input  logic              phase_zero,
  input  logic              gap_zero,
  output logic              phase_load,
  output logic [CNT_W-1:0]  phase_val,
  output logic              gap_load,
  output logic [CNT_W-1:0]  gap_val,
  output logic              capture_en,
  output logic              mem_sel_n,
  output logic              mem_wr_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wbit
);

  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] RC_LOAD = CNT_W'(RC_CYC - 1);

  ctrl_state_e       state_q;
  ctrl_state_e       state_d;
  logic              sel_n_q;
  logic              sel_n_d;
  logic              wr_n_q;
  logic              wr_n_d;
  logic [ADDR_W-1:0] addr_q;
  logic              wbit_q;
  logic              accept;

  assign req_ready = (state_q == ST_IDLE) && gap_zero && init_done;
  assign accept    = req_valid && req_ready;
  assign gap_load  = accept;
  assign gap_val   = RC_LOAD;

  // Next-state and pin logic.
  always_comb begin
    state_d    = state_q;
    sel_n_d    = sel_n_q;
    wr_n_d     = wr_n_q;
    phase_load = 1'b0;
    phase_val  = WR_LOAD;
    capture_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          phase_load = 1'b1;
          sel_n_d    = 1'b0;
          if (req_write) begin
            state_d   = ST_WRITE;
            wr_n_d    = 1'b0;
            phase_val = WR_LOAD;
          end else begin
            state_d   = ST_READ;
            wr_n_d    = 1'b1;
            phase_val = RD_LOAD;
          end
        end
      end
      ST_WRITE: begin
        if (phase_zero) begin
          state_d = ST_WREL;
          wr_n_d  = 1'b1;
        end
      end
      ST_WREL: begin
        state_d = ST_IDLE;
        sel_n_d = 1'b1;
      end
      ST_READ: begin
        if (phase_zero) begin
          state_d    = ST_IDLE;
          sel_n_d    = 1'b1;
          capture_en = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        sel_n_d = 1'b1;
        wr_n_d  = 1'b1;
      end
    endcase
  end

  // State and strobe registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_n_q <= 1'b1;
      wr_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      sel_n_q <= sel_n_d;
      wr_n_q  <= wr_n_d;
    end
  end

  // Address and write data, loaded only on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wbit_q <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr;
      wbit_q <= req_wdata;
    end
  end

  assign mem_sel_n = sel_n_q;
  assign mem_wr_n  = wr_n_q;
  assign mem_addr  = addr_q;
  assign mem_wbit  = wbit_q;

  // Run length of the write strobe, used only by the checks below.
  logic [CNT_W:0] wr_low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_low_run_q <= '0;
    end else if (!wr_n_q) begin
      wr_low_run_q <= wr_low_run_q + 1'b1;
    end else begin
      wr_low_run_q <= '0;
    end
  end

  // R2: a write strobe never appears without the select line active.
  p_wr_inside_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> !mem_sel_n);

  // R3: the write strobe is released while the select line is still active.
  p_wr_ends_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> !mem_sel_n);

  // R3: the write strobe lasts exactly WR_CYC cycles.
  p_wr_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> (wr_low_run_q == (CNT_W+1)'(WR_CYC)));

  // R4: address and data are held through the whole select window.
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && !$past(mem_sel_n)) |-> $stable(mem_addr));

  p_wbit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && !$past(mem_sel_n)) |-> $stable(mem_wbit));

  // R6: no second request is accepted straight after one is taken.
  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8: the memory is deselected whenever the controller is idle and ready.
  p_idle_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && mem_wr_n));

endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CLK_NS = 8,
  parameter int T_RC   = 12,
  parameter int T_PWE  = 10,
  parameter int T_SD   = 7,
  parameter int T_AA   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rd_valid,
  output logic              rd_data,
  output logic              mem_sel_n,
  output logic              mem_wr_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wbit,
  input  logic              mem_rbit
);

  localparam int WR_CYC  = max2(ceil_div(T_PWE, CLK_NS), ceil_div(T_SD, CLK_NS));
  localparam int RD_CYC  = ceil_div(T_AA, CLK_NS) + 1;
  localparam int RC_CYC  = max2(ceil_div(T_RC, CLK_NS), 1);
  localparam int CNT_MAX = max2(max2(WR_CYC, RD_CYC), RC_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  // Reset: asserted asynchronously, released in step with the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  // Holds the handshake closed for one cycle after the internal reset ends.
  logic init_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      init_q <= 1'b0;
    end else begin
      init_q <= 1'b1;
    end
  end

  logic             phase_load;
  logic [CNT_W-1:0] phase_val;
  logic             phase_zero;
  logic             gap_load;
  logic [CNT_W-1:0] gap_val;
  logic             gap_zero;
  logic             capture_en;

  sram_ctrl_fsm #(
    .ADDR_W (ADDR_W),
    .WR_CYC (WR_CYC),
    .RD_CYC (RD_CYC),
    .RC_CYC (RC_CYC),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .init_done  (init_q),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .phase_zero (phase_zero),
    .gap_zero   (gap_zero),
    .phase_load (phase_load),
    .phase_val  (phase_val),
    .gap_load   (gap_load),
    .gap_val    (gap_val),
    .capture_en (capture_en),
    .mem_sel_n  (mem_sel_n),
    .mem_wr_n   (mem_wr_n),
    .mem_addr   (mem_addr),
    .mem_wbit   (mem_wbit)
  );

  // Length of the current access phase.
  sram_cycle_timer #(.CNT_W(CNT_W)) u_phase_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (phase_load),
    .load_val (phase_val),
    .zero     (phase_zero)
  );

  // Minimum spacing between the starts of two accesses.
  sram_cycle_timer #(.CNT_W(CNT_W)) u_gap_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (gap_load),
    .load_val (gap_val),
    .zero     (gap_zero)
  );

  sram_rd_capture u_capture (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .capture_en (capture_en),
    .mem_rbit   (mem_rbit),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  // R1: no request can be taken before the start-up cycle has passed.
  p_closed_at_start_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !init_q |-> !req_ready);

  // R7: the spacing timer is running in the cycle after any acceptance.
  p_gap_armed_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_ready && (RC_CYC > 1)) |=> !gap_zero);

endmodule

// File: tb/sram_access_ctrl_tb.sv
module sram_access_ctrl_tb;

  localparam int AW     = 6;
  localparam int WORDS  = 1 << AW;
  localparam int CLK_NS = 8;
  localparam int T_RC   = 48;
  localparam int T_PWE  = 10;
  localparam int T_SD   = 7;
  localparam int T_AA   = 12;

  // Expected cycle counts, worked out from the requirements.
  localparam int PWE_E = (T_PWE + CLK_NS - 1) / CLK_NS;
  localparam int SD_E  = (T_SD + CLK_NS - 1) / CLK_NS;
  localparam int WR_E  = (PWE_E > SD_E) ? PWE_E : SD_E;
  localparam int AA_E  = (T_AA + CLK_NS - 1) / CLK_NS;
  localparam int RD_E  = AA_E + 1;
  localparam int RC_E  = (T_RC + CLK_NS - 1) / CLK_NS;
  localparam int GAP_W = (RC_E > WR_E + 2) ? RC_E : WR_E + 2;
  localparam int GAP_R = (RC_E > RD_E + 1) ? RC_E : RD_E + 1;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic          req_wdata;
  logic          rd_valid;
  logic          rd_data;
  logic          mem_sel_n;
  logic          mem_wr_n;
  logic [AW-1:0] mem_addr;
  logic          mem_wbit;
  logic          mem_rbit;

  sram_access_ctrl #(
    .ADDR_W (AW),
    .CLK_NS (CLK_NS),
    .T_RC   (T_RC),
    .T_PWE  (T_PWE),
    .T_SD   (T_SD),
    .T_AA   (T_AA)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .mem_sel_n (mem_sel_n),
    .mem_wr_n  (mem_wr_n),
    .mem_addr  (mem_addr),
    .mem_wbit  (mem_wbit),
    .mem_rbit  (mem_rbit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // Cycle-level memory model. The read bit is inverted until the access time has passed.
  logic mem_q [WORDS];
  int   rd_age;

  always @(posedge clk) begin
    if (!mem_sel_n && !mem_wr_n) mem_q[mem_addr] <= mem_wbit;
    if (!mem_sel_n && mem_wr_n) rd_age <= rd_age + 1;
    else rd_age <= 0;
  end

  assign mem_rbit = (rd_age >= AA_E) ? mem_q[mem_addr] : ~mem_q[mem_addr];

  int n_chk;
  int n_bad;
  bit done;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic pat(input int a);
    return 1'(((a * 5 + 3) >> 1) & 1);
  endfunction

  // Monitor: samples two time units after each falling edge.
  bit            mon_en;
  int            cyc;
  int            acc_cyc;
  int            rd_acc_cyc;
  bit            have_prev;
  bit            cont;
  bit            last_w;
  bit            chk_busy;
  logic          rd_exp;
  logic          shadow [WORDS];
  int            we_run;
  int            ce_run;
  int            viol_r2;
  int            viol_r4;
  int            viol_r8;
  int            n_reads;
  int            n_pulses;
  logic          p_sel_n;
  logic          p_wr_n;
  logic [AW-1:0] p_addr;
  logic          p_wbit;

  always @(negedge clk) begin
    #2;
    if (mon_en) begin
      cyc++;
      if (!mem_wr_n && mem_sel_n) viol_r2++;
      if (req_ready && (!mem_sel_n || !mem_wr_n)) viol_r8++;
      if (!mem_sel_n && !p_sel_n && (mem_addr != p_addr || mem_wbit != p_wbit)) viol_r4++;
      if (chk_busy) begin
        check(!req_ready, "R6 ready after accept", int'(req_ready), 0);
        chk_busy = 1'b0;
      end
      // R3: write strobe width and release order.
      if (!mem_wr_n) we_run++;
      else if (!p_wr_n) begin
        check(we_run == WR_E, "R3 write strobe width", we_run, WR_E);
        check(!mem_sel_n, "R3 select held past strobe", int'(mem_sel_n), 0);
        we_run = 0;
      end
      // R3 / R5: length of the select window.
      if (!mem_sel_n) ce_run++;
      else if (!p_sel_n) begin
        if (last_w) check(ce_run == WR_E + 1, "R3 write select window", ce_run, WR_E + 1);
        else check(ce_run == RD_E, "R5 read select window", ce_run, RD_E);
        ce_run = 0;
      end
      // R5 / R9: timing and value of the read result.
      if (rd_valid) begin
        n_pulses++;
        check(cyc - rd_acc_cyc == RD_E + 1, "R5 read result latency", cyc - rd_acc_cyc, RD_E + 1);
        check(rd_data == rd_exp, "R9 read data", int'(rd_data), int'(rd_exp));
      end
      // R6 / R7: acceptance and spacing.
      if (req_valid && req_ready) begin
        if (cont && have_prev) begin
          if (last_w) check(cyc - acc_cyc == GAP_W, "R7 spacing after write", cyc - acc_cyc, GAP_W);
          else check(cyc - acc_cyc == GAP_R, "R7 spacing after read", cyc - acc_cyc, GAP_R);
        end
        acc_cyc   = cyc;
        have_prev = 1'b1;
        cont      = 1'b1;
        last_w    = req_write;
        chk_busy  = 1'b1;
        if (req_write) shadow[req_addr] = req_wdata;
        else begin
          rd_exp     = shadow[req_addr];
          rd_acc_cyc = cyc;
          n_reads++;
        end
      end else if (!req_valid) begin
        cont = 1'b0;
      end
      p_sel_n = mem_sel_n;
      p_wr_n  = mem_wr_n;
      p_addr  = mem_addr;
      p_wbit  = mem_wbit;
    end
  end

  // Driver: called on a falling edge, returns on the falling edge after acceptance.
  task automatic issue(input logic w, input int a, input logic d);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = AW'(a);
    req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
  endtask

  task automatic idle_cycles(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      mem_q[i]  = 1'b0;
      shadow[i] = 1'b0;
    end
    rd_age    = 0;
    p_sel_n   = 1'b1;
    p_wr_n    = 1'b1;
    p_addr    = '0;
    p_wbit    = 1'b0;
    rd_exp    = 1'b0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = 1'b0;

    // R1: reset state.
    repeat (3) @(negedge clk);
    #2;
    check(mem_sel_n == 1'b1, "R1 select in reset", int'(mem_sel_n), 1);
    check(mem_wr_n == 1'b1, "R1 strobe in reset", int'(mem_wr_n), 1);
    check(req_ready == 1'b0, "R1 ready in reset", int'(req_ready), 0);
    check(rd_valid == 1'b0, "R1 result in reset", int'(rd_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(req_ready == 1'b0, "R1 ready before first edge", int'(req_ready), 0);
    @(negedge clk); #2;
    check(req_ready == 1'b0, "R1 ready after first edge", int'(req_ready), 0);
    @(negedge clk); #2;
    check(req_ready == 1'b0, "R1 ready after second edge", int'(req_ready), 0);
    @(negedge clk); #2;
    check(req_ready == 1'b1, "R1 ready after third edge", int'(req_ready), 1);
    @(negedge clk);
    mon_en = 1'b1;

    // Full sweep: write the pattern, read it back.
    for (int a = 0; a < WORDS; a++) issue(1'b1, a, pat(a));
    for (int a = 0; a < WORDS; a++) issue(1'b0, a, 1'b0);
    // Complement in reverse order, then read back.
    for (int a = WORDS - 1; a >= 0; a--) issue(1'b1, a, ~pat(a));
    for (int a = 0; a < WORDS; a++) issue(1'b0, a, 1'b0);
    // Interleaved write/read pairs with a neighbour read.
    for (int a = 0; a < 16; a++) begin
      issue(1'b1, a, 1'(a & 1));
      issue(1'b0, a, 1'b0);
      issue(1'b0, a ^ 1, 1'b0);
    end
    // Isolated accesses after idle periods.
    idle_cycles(5);
    issue(1'b0, 5, 1'b0);
    idle_cycles(9);
    issue(1'b1, 40, 1'b1);
    idle_cycles(3);
    issue(1'b0, 40, 1'b0);
    idle_cycles(12);

    check(viol_r2 == 0, "R2 strobe without select", viol_r2, 0);
    check(viol_r4 == 0, "R4 address or data moved in window", viol_r4, 0);
    check(viol_r8 == 0, "R8 selected while ready", viol_r8, 0);
    check(n_pulses == n_reads, "R5 one result per read", n_pulses, n_reads);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule